// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A countdown watchdog behind a small little-endian register window. Software programs a tick count into the timer-value register and services the watchdog by writing the reload register. A write to the reload register restarts the countdown from the timer value. If software stops servicing it, the first expiry only raises a timeout flag, optionally pulses an SMI request, and starts a fresh countdown. The second expiry in a row sets the second-timeout and boot flags and asks the system for a reset. A strap input or a no-reboot input can block that reset request.

A prescaler turns `TICK_CYCLES` clock cycles into one watchdog tick. The reload register holds the live count, so reading it while the timer runs returns the ticks that remain. The window also has two mailbox bytes, each of which sets a status flag when written. Writing the data-in byte also pulses the SMI request. The window has further spare message bytes. Control register 1 holds a halt bit and a lock bit. Once software sets the lock bit, only reset clears it.

The window is sixteen bits wide and addressed by byte. The word is chosen by `addr_i[4:1]`, and `be_i[0]` selects the byte at the even address (bits 7:0). The map, by byte address, is:

| Address | Register |
|---|---|
| 0x00 | Timer value |
| 0x02 | Reload / live count |
| 0x04 | Control 1 |
| 0x06 | Control 2 |
| 0x08 | Status 1 |
| 0x0A | Status 2 |
| 0x0C | Data-in (low byte) and data-out (high byte) |
| 0x0E | Two message bytes |
| 0x10 | Scratch count (low byte) and software-IRQ byte (high byte) |

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the registers read as follows: timer value 0x0004, control 2 0x0008, word 0x10 reads 0x0300 (software-IRQ byte 0x03), and every other register reads 0. The timer is stopped, and both `smi_req_o` and `rst_req_o` are low.
- R2: A write to the reload register starts the countdown only when the halt bit (control 1 bit 0) is clear and the timer value's low 10 bits exceed 1. Otherwise the written data is stored and reads back unchanged.
- R3: While the timer runs, the reload register reads the remaining ticks, and the count drops by one every `TICK_CYCLES` cycles. After timer-value ticks the timer expires: status 1 bit 0 (timeout) is set and the count reloads from the timer value.
- R4: An expiry that does not request a reset pulses `smi_req_o` for one cycle when `smi_en_i` is high, and leaves it low when `smi_en_i` is low.
- R5: On the second consecutive expiry, status 2 bits 1 (second timeout) and 2 (boot) are set. If `strap_i` and `no_reboot_i` are both low, `rst_req_o` rises and stays high until reset, the timer stops, the count reads 0, and no SMI pulse is given.
- R6: When `strap_i` or `no_reboot_i` is high, the second expiry still sets the status 2 flags. `rst_req_o` stays low and the timer reloads and keeps running.
- R7: A write to the reload register clears the consecutive-expiry count, so two expiries separated by a reload never request a reset.
- R8: A write to control 1 cannot clear the lock bit (bit 1) once it is set. After each write to control 1, the timer restarts from the timer value if it may start, and stops if it may not. A set halt bit always holds the timer stopped.
- R9: A write to the data-in byte sets status 1 bit 1 and pulses `smi_req_o`. A write to the data-out byte sets status 1 bit 2.
- R10: The status registers take plain masked writes: writing 0 clears a flag, and unused bits read 0. Status 1 keeps bits 2:0 and status 2 keeps bits 2:1.
- R11: Byte lanes are little-endian. `be_i[0]` writes bits 7:0 (the even byte address) and `be_i[1]` writes bits 15:8, and a lane whose enable is low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register window |
| be_i | input | 2 | Byte-lane enables |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| smi_en_i | input | 1 | Allows an SMI pulse on expiry |
| strap_i | input | 1 | Reset-inhibit strap |
| no_reboot_i | input | 1 | No-reboot control |
| smi_req_o | output | 1 | One-cycle SMI request pulse |
| rst_req_o | output | 1 | System reset request, held until reset |

## Verification
The bench builds the block with `TICK_CYCLES` set to 4 instead of the default of 30,000,000 cycles (0.6 s at 50 MHz). With the reset timer value of 4, a first expiry then takes 16 cycles and a second takes 32. At that scale the bench can sample the live count one tick before an expiry, the SMI pulse at the expiry edge itself, and full two-stage sequences under each strap and no-reboot combination. It can also check a service write that lands between the two expiries.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int TICK_CYCLES = 30_000_000,
  parameter int CNT_W       = 10,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              smi_en_i,
  input  logic              strap_i,
  input  logic              no_reboot_i,
  output logic              smi_req_o,
  output logic              rst_req_o
);
  localparam int WI = ADDR_W - 1;
  localparam int PW = $clog2(TICK_CYCLES + 1);
  localparam logic [15:0] STS1_MASK = 16'h0007;
  localparam logic [15:0] STS2_MASK = 16'h0006;

  logic [15:0] tval_q, rld_q, ctl1_q, ctl2_q, sts1_q, sts2_q;
  logic [7:0]  din_q, dout_q, msg1_q, msg2_q, wdcnt_q, swirq_q;
  logic        run_q, second_q, rst_req_q, smi_q;
  logic [PW-1:0] presc_q;

  logic [WI-1:0] widx;
  logic          unused_addr_lsb;
  assign widx = addr_i[ADDR_W-1:1];
  assign unused_addr_lsb = addr_i[0];

  function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n, input logic [1:0] b);
    return {b[1] ? n[15:8] : o[15:8], b[0] ? n[7:0] : o[7:0]};
  endfunction

  function automatic logic sel(input logic [WI-1:0] w, input int k);
    return w == WI'(k);
  endfunction

  logic wr_any, wr_rld, wr_ctl1, wr_din, wr_dout;
  assign wr_any  = wr_en_i && (|be_i);
  assign wr_rld  = wr_any && sel(widx, 1);
  assign wr_ctl1 = wr_any && sel(widx, 2);
  assign wr_din  = wr_en_i && be_i[0] && sel(widx, 6);
  assign wr_dout = wr_en_i && be_i[1] && sel(widx, 6);

  logic [15:0] wmerged_rld, ctl1_new;
  assign wmerged_rld = mrg(rld_q, wdata_i, be_i);
  assign ctl1_new    = mrg(ctl1_q, wdata_i, be_i) | (ctl1_q & 16'h0002);

  logic tval_ok;
  assign tval_ok = tval_q[CNT_W-1:0] > CNT_W'(1);

  logic tick, expire, fire_rst;
  assign tick     = run_q && (presc_q == PW'(TICK_CYCLES - 1));
  assign expire   = tick && (rld_q[CNT_W-1:0] <= CNT_W'(1));
  assign fire_rst = expire && second_q && !strap_i && !no_reboot_i;

  logic [15:0] sts1_nxt, sts2_nxt;
  always_comb begin
    sts1_nxt = (wr_any && sel(widx, 4)) ? (mrg(sts1_q, wdata_i, be_i) & STS1_MASK) : sts1_q;
    sts2_nxt = (wr_any && sel(widx, 5)) ? (mrg(sts2_q, wdata_i, be_i) & STS2_MASK) : sts2_q;
    if (expire) sts1_nxt[0] = 1'b1;
    if (wr_din) sts1_nxt[1] = 1'b1;
    if (wr_dout) sts1_nxt[2] = 1'b1;
    if (expire && second_q) sts2_nxt[2:1] = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tval_q <= 16'h0004; rld_q <= '0; ctl1_q <= '0; ctl2_q <= 16'h0008;
      sts1_q <= '0; sts2_q <= '0;
      din_q <= '0; dout_q <= '0; msg1_q <= '0; msg2_q <= '0;
      wdcnt_q <= '0; swirq_q <= 8'h03;
      run_q <= 1'b0; second_q <= 1'b0; rst_req_q <= 1'b0; smi_q <= 1'b0;
      presc_q <= '0;
    end else begin
      smi_q  <= 1'b0;
      sts1_q <= sts1_nxt;
      sts2_q <= sts2_nxt;
      if (run_q) presc_q <= tick ? '0 : presc_q + PW'(1);
      if (tick && !expire) rld_q[CNT_W-1:0] <= rld_q[CNT_W-1:0] - CNT_W'(1);
      if (expire) begin
        second_q <= !second_q;
        if (fire_rst) begin
          rst_req_q <= 1'b1;
          run_q     <= 1'b0;
          rld_q     <= '0;
        end else begin
          if (smi_en_i) smi_q <= 1'b1;
          rld_q <= tval_q;
        end
      end
      if (wr_any && sel(widx, 0)) tval_q <= mrg(tval_q, wdata_i, be_i);
      if (wr_any && sel(widx, 3)) ctl2_q <= mrg(ctl2_q, wdata_i, be_i);
      if (wr_en_i && sel(widx, 7)) begin
        if (be_i[0]) msg1_q <= wdata_i[7:0];
        if (be_i[1]) msg2_q <= wdata_i[15:8];
      end
      if (wr_en_i && sel(widx, 8)) begin
        if (be_i[0]) wdcnt_q <= wdata_i[7:0];
        if (be_i[1]) swirq_q <= wdata_i[15:8];
      end
      if (wr_din) begin
        din_q <= wdata_i[7:0];
        smi_q <= 1'b1;
      end
      if (wr_dout) dout_q <= wdata_i[15:8];
      if (wr_rld) begin
        second_q <= 1'b0;
        if (!ctl1_q[0] && tval_ok) begin
          rld_q <= tval_q; run_q <= 1'b1; presc_q <= '0;
        end else begin
          rld_q <= wmerged_rld;
        end
      end
      if (wr_ctl1) begin
        ctl1_q <= ctl1_new;
        if (!ctl1_new[0] && tval_ok) begin
          rld_q <= tval_q; run_q <= 1'b1; presc_q <= '0;
        end else begin
          run_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (sel(widx, 0)) rdata_o = tval_q;
    else if (sel(widx, 1)) rdata_o = rld_q;
    else if (sel(widx, 2)) rdata_o = ctl1_q;
    else if (sel(widx, 3)) rdata_o = ctl2_q;
    else if (sel(widx, 4)) rdata_o = sts1_q;
    else if (sel(widx, 5)) rdata_o = sts2_q;
    else if (sel(widx, 6)) rdata_o = {dout_q, din_q};
    else if (sel(widx, 7)) rdata_o = {msg2_q, msg1_q};
    else if (sel(widx, 8)) rdata_o = {swirq_q, wdcnt_q};
  end

  assign smi_req_o = smi_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req_o,
  input logic             strap_i,
  input logic             no_reboot_i,
  input logic             smi_req_o,
  input logic             smi_en_i,
  input logic             wr_en_i,
  input logic             run_q,
  input logic [CNT_W-1:0] tval_f,
  input logic [1:0]       ctl_bits
);
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o); // R5
  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(!strap_i && !no_reboot_i)); // R6
  AST_START_NEEDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(tval_f) > CNT_W'(1))); // R2
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[1] |=> ctl_bits[1]); // R8
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[0] |-> !run_q); // R8
  AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req_o |-> $past(smi_en_i || wr_en_i)); // R4
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rst_req_o(rst_req_o), .strap_i(strap_i),
  .no_reboot_i(no_reboot_i), .smi_req_o(smi_req_o), .smi_en_i(smi_en_i),
  .wr_en_i(wr_en_i), .run_q(run_q), .tval_f(tval_q[CNT_W-1:0]),
  .ctl_bits(ctl1_q[1:0])
);

// File: tb/wdt_two_stage_tb_top.sv
module wdt_two_stage_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [1:0] be_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic smi_en_i = 1'b0, strap_i = 1'b0, no_reboot_i = 1'b0;
  logic smi_req_o, rst_req_o;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  wdt_two_stage #(.TICK_CYCLES(4), .CNT_W(10), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .smi_en_i(smi_en_i), .strap_i(strap_i),
    .no_reboot_i(no_reboot_i), .smi_req_o(smi_req_o), .rst_req_o(rst_req_o));

  // {byte address, lane enables, write data, expected read}
  localparam logic [38:0] VEC [10] = '{
    {5'h0E, 2'b11, 16'hA55A, 16'hA55A},
    {5'h0E, 2'b01, 16'h1234, 16'hA534},
    {5'h0E, 2'b10, 16'h7700, 16'h7734},
    {5'h10, 2'b01, 16'h00C3, 16'h03C3},
    {5'h06, 2'b10, 16'hAB00, 16'hAB08},
    {5'h08, 2'b11, 16'hFFFF, 16'h0007},
    {5'h08, 2'b11, 16'h0000, 16'h0000},
    {5'h0A, 2'b11, 16'hFFFF, 16'h0006},
    {5'h0A, 2'b11, 16'h0002, 16'h0002},
    {5'h0A, 2'b11, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] b);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; be_i = b;
    @(negedge clk);
    wr_en_i = 1'b0; be_i = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wt(3); rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) got hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    wt(3); rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, v); chk("R1 timer value", v, 16'h0004);
    rd(5'h06, v); chk("R1 control 2", v, 16'h0008);
    rd(5'h10, v); chk("R1 swirq word", v, 16'h0300);
    rd(5'h02, v); chk("R1 reload", v, 16'h0000);
    rd(5'h08, v); chk("R1 status 1", v, 16'h0000);
    chk("R1 outputs", {14'd0, smi_req_o, rst_req_o}, 16'h0000);
    wt(1);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][38:34], VEC[i][31:16], VEC[i][33:32]);
      rd(VEC[i][38:34], v);
      chk(i >= 5 ? "R10 status write" : "R11 byte lanes", v, VEC[i][15:0]);
    end

    // R2 no start with small timer value or halt
    wr(5'h00, 16'h0001, 2'b11);
    wr(5'h02, 16'h0155, 2'b11);
    wt(10); rd(5'h02, v); chk("R2 tval=1 stores data", v, 16'h0155);
    wr(5'h00, 16'h0004, 2'b11);
    wr(5'h04, 16'h0001, 2'b11);
    wr(5'h02, 16'h0020, 2'b11);
    wt(10); rd(5'h02, v); chk("R2 halted stores data", v, 16'h0020);
    // R8 clearing halt restarts
    wr(5'h04, 16'h0000, 2'b11);
    wt(5); rd(5'h02, v); chk("R8 restart count", v, 16'h0003);
    wr(5'h04, 16'h0002, 2'b11);
    wr(5'h04, 16'h0000, 2'b11);
    rd(5'h04, v); chk("R8 lock sticky", v, 16'h0002);
    wr(5'h04, 16'h0001, 2'b11);
    rd(5'h04, v); chk("R8 halt with lock", v, 16'h0003);
    rd(5'h02, v); wt(8); rd(5'h02, v2); chk("R8 halt stops count", v2, v);

    // R3 R4 R5 R7 full sequence
    smi_en_i = 1'b1;
    wr(5'h04, 16'h0002, 2'b11);
    wr(5'h02, 16'h0000, 2'b11);
    wt(15); rd(5'h02, v); chk("R3 count before expiry", v, 16'h0001);
    rd(5'h08, v); chk("R3 no timeout yet", v, 16'h0000);
    wt(1); rd(5'h08, v); chk("R3 timeout flag", v, 16'h0001);
    rd(5'h02, v); chk("R3 reloaded", v, 16'h0004);
    chk("R4 smi pulse", {15'd0, smi_req_o}, 16'h0001);
    wt(1); chk("R4 smi one cycle", {15'd0, smi_req_o}, 16'h0000);
    wt(3); wr(5'h02, 16'h0000, 2'b11);
    wt(16); rd(5'h0A, v); chk("R7 no second after reload", v, 16'h0000);
    chk("R7 no reset", {15'd0, rst_req_o}, 16'h0000);
    wt(16); rd(5'h0A, v); chk("R5 second flags", v, 16'h0006);
    chk("R5 reset request", {15'd0, rst_req_o}, 16'h0001);
    chk("R5 no smi on reset", {15'd0, smi_req_o}, 16'h0000);
    rd(5'h02, v); chk("R5 count zero", v, 16'h0000);
    wt(8); rd(5'h02, v); chk("R5 stopped", v, 16'h0000);
    chk("R5 held", {15'd0, rst_req_o}, 16'h0001);

    // R6 strap and no-reboot block reset
    do_reset();
    chk("R1 reset clears request", {15'd0, rst_req_o}, 16'h0000);
    smi_en_i = 1'b0; strap_i = 1'b1;
    wr(5'h02, 16'h0000, 2'b11);
    wt(16); chk("R4 no smi when disabled", {15'd0, smi_req_o}, 16'h0000);
    rd(5'h08, v); chk("R3 timeout flag again", v, 16'h0001);
    wt(16); rd(5'h0A, v); chk("R6 strap flags", v, 16'h0006);
    chk("R6 strap no reset", {15'd0, rst_req_o}, 16'h0000);
    rd(5'h02, v); chk("R6 strap reloaded", v, 16'h0004);
    strap_i = 1'b0; no_reboot_i = 1'b1;
    wt(32); chk("R6 no-reboot no reset", {15'd0, rst_req_o}, 16'h0000);
    rd(5'h02, v); chk("R6 no-reboot reloaded", v, 16'h0004);

    // R9 mailboxes
    wr(5'h04, 16'h0001, 2'b11);
    wr(5'h08, 16'h0000, 2'b11);
    wr(5'h0C, 16'h005A, 2'b01);
    chk("R9 data-in smi", {15'd0, smi_req_o}, 16'h0001);
    rd(5'h08, v); chk("R9 data-in flag", v, 16'h0002);
    wr(5'h0C, 16'hC300, 2'b10);
    rd(5'h08, v); chk("R9 data-out flag", v, 16'h0006);
    rd(5'h0C, v); chk("R9 mailbox bytes", v, 16'hC35A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule